// File: doc/BRIEF.md
# Battery Node Sleep and Wake Controller

This block runs the duty cycle of a battery-powered radio node. A strap input is looked at once, in the first clock after reset. If the strap is high the node stays awake for good and the block does nothing more. If the strap is low the node enters sleep. While asleep it counts a programmable sleep period in 5-second units, built from a half-second tick. It also compares a masked group of input pins against a copy of their levels taken when sleep began.

Either cause wakes the node. The block then raises a one-cycle request for a broadcast check-in packet. The packet type tells the two causes apart. A pin wake carries the present pin levels and a bitmap of the pins that moved. A timer wake carries no data. The block then waits a programmable number of half-seconds for a host reply. If none arrives it requests the same packet once more. After a second silent wait it goes back to sleep. A reply holds the node awake until a sleep command arrives. A sleep command also cuts either wait short. Transmission of the packet is left to the surrounding logic.

Top module: `swc_sleep_wake_ctrl`

## Requirements
- R1: With `lp_strap_n` high in the first cycle after reset, `asleep` stays 0 and `chk_req` never pulses, whatever the pins, ticks or sleep commands do.
- R2: `asleep` and `chk_req` are 0 during reset. With `lp_strap_n` low in the first cycle after reset, `asleep` is 1 from the second cycle after reset.
- R3: Asleep, with sleep period P, the timer wake happens on the 10*max(P,1)-th `half_tick` counted from sleep entry. It requests command 0xC2 with `chk_len` 0.
- R4: A level change in either direction on a pin whose `pin_watch_mask` bit is 1 wakes the node. It requests command 0xC1 with `chk_len` 2, `chk_pins` equal to the pin levels at the wake, and `chk_changed` bit i set exactly for the masked pins i that differ from the sleep-entry copy.
- R5: A change on a pin whose mask bit is 0 does not wake the node.
- R6: When a masked pin change and the last timer tick fall in the same cycle, the pin wake (0xC1) wins.
- R7: With reply wait W, if no reply or sleep command arrives within max(W,1) half-ticks of waiting, the same packet is requested a second time. After a second silent wait of the same length the node sleeps.
- R8: A `reply_seen` pulse during the wait cancels the retry, and the node stays awake with no further requests until `sleep_cmd`.
- R9: A `sleep_cmd` pulse during the wait, or after a reply, puts the node to sleep in the next cycle. The pin copy and the sleep count restart at that entry.
- R10: `chk_req` is a single-cycle pulse. It rises in the cycle in which `asleep` falls, and again at the retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lp_strap_n | input | 1 | Low-power strap, low enables the sleep cycle |
| half_tick | input | 1 | One-cycle pulse every half-second |
| pin_in | input | PIN_W | Watched input pin levels |
| pin_watch_mask | input | PIN_W | 1 selects a pin as a wake source |
| sleep_period | input | PERIOD_W | Sleep length in 5-second units |
| reply_wait | input | WAIT_W | Reply wait in half-seconds |
| reply_seen | input | 1 | Pulse, a host reply has arrived |
| sleep_cmd | input | 1 | Pulse, return to sleep now |
| chk_req | output | 1 | Check-in packet request pulse |
| chk_cmd | output | 8 | Check-in command, 0xC1 pin or 0xC2 timer |
| chk_len | output | 2 | Number of data bytes, 0 or 2 |
| chk_pins | output | PIN_W | Data byte 0: pin levels at the wake |
| chk_changed | output | PIN_W | Data byte 1: changed-pin bitmap |
| asleep | output | 1 | Node is in sleep |

## Verification
The states that are hardest to reach from the ports are the second wait after a retry and the cycle in which the tenth divided tick lands together with a pin change. To reach the retry, the bench lets the first wait expire tick by tick and counts the request pulses, then lets the second wait expire too. To reach the shared cycle, it gives nine ticks first and then raises the last tick in the same cycle as a masked pin change. The falling-edge pin case is reached by re-entering sleep with the pins held high, so that the copy taken at sleep entry is all ones.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [2:0] {
    ST_INIT, ST_SLEEP, ST_SEND, ST_WAIT, ST_HOLD, ST_AWAKE
  } swc_state_e;

  localparam logic [7:0] CMD_PIN_WAKE = 8'hC1;
  localparam logic [7:0] CMD_TMR_WAKE = 8'hC2;

  // true when one more event reaches the limit; a limit of zero acts as one
  function automatic logic reached(input logic [31:0] count, input logic [31:0] limit);
    logic [32:0] eff;
    eff = (limit == 32'd0) ? 33'd1 : {1'b0, limit};
    return ({1'b0, count} + 33'd1) >= eff;
  endfunction
endpackage

// File: rtl/swc_sleep_timer.sv
module swc_sleep_timer #(
  parameter int DIV = 10,
  parameter int UW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic          tick,
  input  logic [UW-1:0] period,
  output logic          expire
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q;
  logic [UW-1:0] unit_q;
  logic          last_div;

  assign last_div = (div_q == DW'(DIV - 1));
  assign expire   = run && tick && last_div && swc_pkg::reached(32'(unit_q), 32'(period));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      unit_q <= '0;
    end else if (clear) begin
      div_q  <= '0;
      unit_q <= '0;
    end else if (run && tick) begin
      if (last_div) begin
        div_q  <= '0;
        unit_q <= unit_q + UW'(1);
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end
endmodule

// File: rtl/swc_wait_timer.sv
module swc_wait_timer #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic          tick,
  input  logic [HW-1:0] limit,
  output logic          expire
);
  logic [HW-1:0] cnt_q;

  assign expire = run && tick && swc_pkg::reached(32'(cnt_q), 32'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clear)        cnt_q <= '0;
    else if (run && tick)  cnt_q <= cnt_q + HW'(1);
  end
endmodule

// File: rtl/swc_pin_watch.sv
module swc_pin_watch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] mask,
  output logic [W-1:0] changed,
  output logic         hit
);
  logic [W-1:0] snap_q;

  function automatic logic [W-1:0] diff_bits(input logic [W-1:0] now_v,
                                              input logic [W-1:0] ref_v,
                                              input logic [W-1:0] sel);
    return (now_v ^ ref_v) & sel;
  endfunction

  assign changed = diff_bits(pins, snap_q, mask);
  assign hit     = |changed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (capture) snap_q <= pins;
  end
endmodule

// File: rtl/swc_sleep_wake_ctrl.sv
module swc_sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int PIN_W           = 8,
  parameter int PERIOD_W        = 16,
  parameter int WAIT_W          = 8,
  parameter int HALVES_PER_UNIT = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lp_strap_n,
  input  logic                half_tick,
  input  logic [PIN_W-1:0]    pin_in,
  input  logic [PIN_W-1:0]    pin_watch_mask,
  input  logic [PERIOD_W-1:0] sleep_period,
  input  logic [WAIT_W-1:0]   reply_wait,
  input  logic                reply_seen,
  input  logic                sleep_cmd,
  output logic                chk_req,
  output logic [7:0]          chk_cmd,
  output logic [1:0]          chk_len,
  output logic [PIN_W-1:0]    chk_pins,
  output logic [PIN_W-1:0]    chk_changed,
  output logic                asleep
);
  swc_state_e state_q, nxt;

  // named internal events
  logic             pin_hit, tmr_expire, wait_expire;
  logic             wake_pin_evt, wake_tmr_evt, retry_evt, give_up_evt, enter_sleep;
  logic [PIN_W-1:0] pin_changed;
  logic             attempt_q;

  logic [7:0]       cmd_q;
  logic [1:0]       len_q;
  logic [PIN_W-1:0] pins_q, chg_q;

  swc_pin_watch #(.W(PIN_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .capture(enter_sleep),
    .pins(pin_in), .mask(pin_watch_mask),
    .changed(pin_changed), .hit(pin_hit)
  );

  swc_sleep_timer #(.DIV(HALVES_PER_UNIT), .UW(PERIOD_W)) u_sleep_tmr (
    .clk(clk), .rst_n(rst_n), .clear(enter_sleep),
    .run(state_q == ST_SLEEP), .tick(half_tick),
    .period(sleep_period), .expire(tmr_expire)
  );

  swc_wait_timer #(.HW(WAIT_W)) u_wait_tmr (
    .clk(clk), .rst_n(rst_n), .clear(state_q == ST_SEND),
    .run(state_q == ST_WAIT), .tick(half_tick),
    .limit(reply_wait), .expire(wait_expire)
  );

  assign wake_pin_evt = (state_q == ST_SLEEP) && pin_hit;
  assign wake_tmr_evt = (state_q == ST_SLEEP) && tmr_expire && !pin_hit;
  assign retry_evt    = (state_q == ST_WAIT) && !sleep_cmd && !reply_seen
                        && wait_expire && !attempt_q;
  assign give_up_evt  = (state_q == ST_WAIT) && !sleep_cmd && !reply_seen
                        && wait_expire && attempt_q;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_INIT:  nxt = lp_strap_n ? ST_AWAKE : ST_SLEEP;
      ST_SLEEP: if (wake_pin_evt || wake_tmr_evt) nxt = ST_SEND;
      ST_SEND:  nxt = ST_WAIT;
      ST_WAIT: begin
        if (sleep_cmd)        nxt = ST_SLEEP;
        else if (reply_seen)  nxt = ST_HOLD;
        else if (retry_evt)   nxt = ST_SEND;
        else if (give_up_evt) nxt = ST_SLEEP;
      end
      ST_HOLD:  if (sleep_cmd) nxt = ST_SLEEP;
      ST_AWAKE: nxt = ST_AWAKE;
      default:  nxt = ST_INIT;
    endcase
  end

  assign enter_sleep = (nxt == ST_SLEEP) && (state_q != ST_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_INIT;
      attempt_q <= 1'b0;
      cmd_q     <= '0;
      len_q     <= '0;
      pins_q    <= '0;
      chg_q     <= '0;
    end else begin
      state_q <= nxt;
      if (wake_pin_evt) begin
        attempt_q <= 1'b0;
        cmd_q     <= CMD_PIN_WAKE;
        len_q     <= 2'd2;
        pins_q    <= pin_in;
        chg_q     <= pin_changed;
      end else if (wake_tmr_evt) begin
        attempt_q <= 1'b0;
        cmd_q     <= CMD_TMR_WAKE;
        len_q     <= 2'd0;
        pins_q    <= '0;
        chg_q     <= '0;
      end else if (retry_evt) begin
        attempt_q <= 1'b1;
      end
    end
  end

  assign chk_req     = (state_q == ST_SEND);
  assign chk_cmd     = cmd_q;
  assign chk_len     = len_q;
  assign chk_pins    = pins_q;
  assign chk_changed = chg_q;
  assign asleep      = (state_q == ST_SLEEP);
endmodule

// File: rtl/swc_chk.sv
module swc_chk
  import swc_pkg::*;
#(
  parameter int PIN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input swc_state_e       state,
  input logic             chk_req,
  input logic [7:0]       chk_cmd,
  input logic [1:0]       chk_len,
  input logic [PIN_W-1:0] chk_changed,
  input logic             asleep,
  input logic             sleep_cmd,
  input logic             retry_evt
);
  a_r1_awake_is_final: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_AWAKE |=> state == ST_AWAKE && !asleep && !chk_req);

  a_r10_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |=> !chk_req);

  a_r10_req_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> chk_req);

  a_r3_timer_pkt_empty: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req && chk_cmd == CMD_TMR_WAKE |-> chk_len == 2'd0);

  a_r4_pin_pkt_bitmap: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req && chk_cmd == CMD_PIN_WAKE |-> chk_len == 2'd2 && chk_changed != '0);

  a_r9_sleep_cmd_obeyed: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT || state == ST_HOLD) && sleep_cmd |=> asleep);

  a_r8_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_HOLD && !sleep_cmd |=> state == ST_HOLD && !chk_req);

  a_r7_retry_resends: assert property (@(posedge clk) disable iff (!rst_n)
    retry_evt |=> chk_req && $stable(chk_cmd));
endmodule

bind swc_sleep_wake_ctrl swc_chk #(.PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state_q), .chk_req(chk_req),
  .chk_cmd(chk_cmd), .chk_len(chk_len), .chk_changed(chk_changed),
  .asleep(asleep), .sleep_cmd(sleep_cmd), .retry_evt(retry_evt)
);

// File: tb/swc_sleep_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module swc_sleep_wake_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_strap_n = 1'b0;
  logic half_tick = 1'b0;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_watch_mask = 8'hFF;
  logic [15:0] sleep_period = 16'd2;
  logic [7:0] reply_wait = 8'd2;
  logic reply_seen = 1'b0;
  logic sleep_cmd = 1'b0;
  logic chk_req;
  logic [7:0] chk_cmd;
  logic [1:0] chk_len;
  logic [7:0] chk_pins, chk_changed;
  logic asleep;

  int n_run = 0, n_fail = 0, req_cnt = 0;
  logic [7:0] got_cmd, got_pins, got_chg;
  logic [1:0] got_len;
  bit done = 0;

  always #4 clk = ~clk;

  swc_sleep_wake_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .lp_strap_n(lp_strap_n), .half_tick(half_tick),
    .pin_in(pin_in), .pin_watch_mask(pin_watch_mask), .sleep_period(sleep_period),
    .reply_wait(reply_wait), .reply_seen(reply_seen), .sleep_cmd(sleep_cmd),
    .chk_req(chk_req), .chk_cmd(chk_cmd), .chk_len(chk_len), .chk_pins(chk_pins),
    .chk_changed(chk_changed), .asleep(asleep)
  );

  always @(posedge clk) begin
    if (rst_n && chk_req) begin
      req_cnt++;
      got_cmd  = chk_cmd;
      got_len  = chk_len;
      got_pins = chk_pins;
      got_chg  = chk_changed;
    end
  end

  function automatic int sleep_ticks(int p);
    return 10 * ((p == 0) ? 1 : p);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tick_once();
    @(posedge clk); #1 half_tick = 1'b1;
    @(posedge clk); #1 half_tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick_once();
  endtask

  task automatic pulse_sleep();
    @(posedge clk); #1 sleep_cmd = 1'b1;
    @(posedge clk); #1 sleep_cmd = 1'b0;
  endtask

  task automatic pulse_reply();
    @(posedge clk); #1 reply_seen = 1'b1;
    @(posedge clk); #1 reply_seen = 1'b0;
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0; lp_strap_n = strap; pin_in = 8'h00;
    cyc(3);
    @(negedge clk);
    chk("R2 reset asleep", 32'(asleep), 0);
    chk("R2 reset req", 32'(chk_req), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    cyc(3);
  endtask

  // {mask, new pin levels, expected changed bitmap}; snapshot is 0x00
  localparam logic [23:0] PIN_ROWS [6] = '{
    {8'hFF, 8'h01, 8'h01},
    {8'h0F, 8'hF0, 8'h00},
    {8'h0F, 8'h3C, 8'h0C},
    {8'h80, 8'h80, 8'h80},
    {8'h00, 8'hFF, 8'h00},
    {8'hAA, 8'hFF, 8'hAA}
  };

  initial begin
    #1600000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    do_reset(1'b0);
    @(negedge clk);
    chk("R2 asleep after strap low", 32'(asleep), 1);

    // R3 timer wake after 10*P ticks, C2 with no data
    sleep_period = 16'd2; reply_wait = 8'd2; pin_watch_mask = 8'hFF;
    base = req_cnt;
    ticks(sleep_ticks(2) - 1);
    cyc(2); @(negedge clk);
    chk("R3 no wake before last tick", 32'(req_cnt - base), 0);
    chk("R3 still asleep", 32'(asleep), 1);
    tick_once(); cyc(1); @(negedge clk);
    chk("R3 wake count", 32'(req_cnt - base), 1);
    chk("R3 wake cmd", 32'(got_cmd), 32'hC2);
    chk("R3 wake len", 32'(got_len), 0);

    // R7 one retry then back to sleep
    tick_once(); cyc(2); @(negedge clk);
    chk("R7 no retry before wait end", 32'(req_cnt - base), 1);
    tick_once(); cyc(2); @(negedge clk);
    chk("R7 retry sent", 32'(req_cnt - base), 2);
    chk("R7 retry cmd same", 32'(got_cmd), 32'hC2);
    chk("R7 awake during second wait", 32'(asleep), 0);
    ticks(2); cyc(2); @(negedge clk);
    chk("R7 asleep after second wait", 32'(asleep), 1);
    chk("R7 no third request", 32'(req_cnt - base), 2);

    // R4/R5 table of pin cases, period large so the timer stays quiet
    sleep_period = 16'd1000;
    for (int r = 0; r < 6; r++) begin
      logic [7:0] m, p, e;
      {m, p, e} = PIN_ROWS[r];
      base = req_cnt;
      @(posedge clk); #1 pin_watch_mask = m;
      @(posedge clk); #1 pin_in = p;
      cyc(3); @(negedge clk);
      if (e == 8'h00) begin
        chk($sformatf("R5 row %0d no wake", r), 32'(req_cnt - base), 0);
        chk($sformatf("R5 row %0d asleep", r), 32'(asleep), 1);
        @(posedge clk); #1 pin_in = 8'h00;
      end else begin
        chk($sformatf("R4 row %0d wake", r), 32'(req_cnt - base), 1);
        chk($sformatf("R4 row %0d cmd", r), 32'(got_cmd), 32'hC1);
        chk($sformatf("R4 row %0d len", r), 32'(got_len), 2);
        chk($sformatf("R4 row %0d pins", r), 32'(got_pins), 32'(p));
        chk($sformatf("R4 row %0d changed", r), 32'(got_chg), 32'(e));
        pulse_reply();
        if (r == 0) begin
          ticks(6); cyc(2); @(negedge clk);
          chk("R8 no retry after reply", 32'(req_cnt - base), 1);
          chk("R8 held awake", 32'(asleep), 0);
        end
        @(posedge clk); #1 pin_in = 8'h00;
        pulse_sleep(); @(negedge clk);
        chk($sformatf("R9 row %0d asleep after cmd", r), 32'(asleep), 1);
      end
    end

    // R4 falling direction: re-enter sleep with pins high
    pin_watch_mask = 8'hFF;
    base = req_cnt;
    @(posedge clk); #1 pin_in = 8'hFF;
    cyc(3); pulse_reply();
    pulse_sleep(); cyc(2);
    @(posedge clk); #1 pin_in = 8'hFE;
    cyc(3); @(negedge clk);
    chk("R4 falling wake", 32'(req_cnt - base), 2);
    chk("R4 falling pins", 32'(got_pins), 32'hFE);
    chk("R4 falling changed", 32'(got_chg), 32'h01);

    // R9 sleep_cmd during wait restarts pin copy and sleep count
    sleep_period = 16'd1;
    base = req_cnt;
    pulse_sleep(); @(negedge clk);
    chk("R9 asleep after cmd in wait", 32'(asleep), 1);
    ticks(9); cyc(2); @(negedge clk);
    chk("R9 count restarted, no wake", 32'(req_cnt - base), 0);
    tick_once(); cyc(1); @(negedge clk);
    chk("R9 timer wake after reload", 32'(req_cnt - base), 1);
    chk("R9 timer wake cmd", 32'(got_cmd), 32'hC2);
    pulse_sleep();

    // R6 pin change and final tick in the same cycle
    base = req_cnt;
    ticks(9);
    @(posedge clk); #1 half_tick = 1'b1; pin_in = 8'hFC;
    @(posedge clk); #1 half_tick = 1'b0;
    cyc(2); @(negedge clk);
    chk("R6 one request", 32'(req_cnt - base), 1);
    chk("R6 pin wins", 32'(got_cmd), 32'hC1);
    chk("R6 changed", 32'(got_chg), 32'h02);
    pulse_sleep();

    // R1 strap high keeps the node awake
    do_reset(1'b1);
    base = req_cnt;
    @(posedge clk); #1 pin_in = 8'h55;
    pulse_sleep(); ticks(25);
    @(negedge clk);
    chk("R1 never asleep", 32'(asleep), 0);
    chk("R1 no requests", 32'(req_cnt - base), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule